// File: doc/BRIEF.md
# 16-bit Prescaled Event Timer

This block is a 16-bit up-counter for a peripheral subsystem. Software loads its low and high bytes through byte write strobes and sets it up through a control byte. The control byte has an enable bit, a clock-source select and a two-bit prescale field. The count advances on the block clock or on rising edges of an external input. The external input is first passed through a synchronizer and then reduced by a prescaler of ratio 1, 2, 4 or 8.

When the count wraps past its top value, the block pulses an overflow interrupt. A neighbouring compare unit reads the running count and gets an equality pulse when the count reaches the compare value it supplies. That unit can also reset the count with a synchronous clear request. The prescaler keeps its phase when either count byte is written, so writing the count does not shift the tick grid.

Top module: `evt_timer16`

## Requirements
- R1: After reset, `count`, `ctl_rd`, `ovf_irq` and `cmp_eq` are all zero.
- R2: Control byte layout: bit 0 is enable, bit 1 is source select (0 = block clock, 1 = external input), and bits 5:4 are the prescale field p. With the internal source enabled, `count` rises by exactly one every 2^p clock cycles and never by more than one per cycle.
- R3: Counting past 0xFFFF gives 0x0000. `ovf_irq` is high for exactly the one cycle in which `count` first shows that 0x0000, and is low at all other times.
- R4: With the external source enabled, every 2^p-th rising edge of `ext_clk` adds one to `count`. The change is visible after the third clock edge, counting the first edge that samples `ext_clk` high.
- R5: `wr_lo` loads `wr_data` into count bits 7:0 and `wr_hi` loads it into bits 15:8. Both may be given in the same cycle. In a write cycle the count does not increment, and a write never resets or reloads the prescaler.
- R6: `cmp_clear` takes priority over writes and increments, and gives `count` = 0 on the next cycle.
- R7: While the enable bit is 0 the count and the prescaler hold their values. Setting the bit again resumes counting from the held count and prescaler phase.
- R8: A control write that changes the prescale field reloads the prescaler to the new ratio, so the next increment comes 2^p ticks later. A control write that keeps the field unchanged leaves the prescaler phase alone.
- R9: `cmp_eq` is high in the first cycle in which `cmp_en` is high and `count` equals `cmp_value`. It stays low while that equality persists.
- R10: `ctl_rd` returns the written control bits 0, 1, 4 and 5, and zero in every other bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_lo | input | 1 | Write strobe for count bits 7:0 |
| wr_hi | input | 1 | Write strobe for count bits 15:8 |
| wr_ctl | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data shared by all strobes |
| ext_clk | input | 1 | Asynchronous external count input |
| cmp_en | input | 1 | Compare unit enables the equality output |
| cmp_value | input | 16 | Value compared against the count |
| cmp_clear | input | 1 | Synchronous clear request from the compare unit |
| count | output | 16 | Current count |
| ctl_rd | output | 8 | Control byte read-back |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |
| cmp_eq | output | 1 | One-cycle equality pulse |

## Verification
The bench preloads 0xFFFE and 0xFFFF to reach the wrap. A design that flags overflow one cycle off, or flags it on a written 0x0000, would show the interrupt at the wrong cycle. It writes a count byte halfway through a prescale period. A design that resets the prescaler there would delay the next increment by a full period. It also rewrites the control byte with and without a prescale change, because reloading in the wrong case shifts every later tick. Random stimulus then mixes external edges, freezes, clears and held equality windows. This exposes a wrong synchronizer depth, a write that loses priority to a clear, and an equality pulse that repeats while the match persists.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_SRC_BIT = 1;
   localparam int CTL_PS_LSB  = 4;
   localparam int CTL_PS_W    = 2;

   typedef struct packed {
      logic [CTL_PS_W-1:0] ps;
      logic                src;
      logic                en;
   } tmr_ctl_t;

   function automatic tmr_ctl_t ctl_unpack(input logic [7:0] b);
      tmr_ctl_t c;
      c.en  = b[CTL_EN_BIT];
      c.src = b[CTL_SRC_BIT];
      c.ps  = b[CTL_PS_LSB +: CTL_PS_W];
      return c;
   endfunction

   function automatic logic [7:0] ctl_pack(input tmr_ctl_t c);
      logic [7:0] b;
      b = '0;
      b[CTL_EN_BIT]  = c.en;
      b[CTL_SRC_BIT] = c.src;
      b[CTL_PS_LSB +: CTL_PS_W] = c.ps;
      return b;
   endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("evt_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEL_W-1:0] ratio_sel,
   output logic             carry
);
   localparam int PCNT_W = 1 << SEL_W;
   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] reload;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad
         $error("evt_prescaler: SEL_W out of range");
      end
   endgenerate

   assign reload = PCNT_W'(1) << ratio_sel;
   assign carry  = tick && !load && (pcnt == PCNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt <= PCNT_W'(1);
      else if (load)  pcnt <= reload;
      else if (carry) pcnt <= reload;
      else if (tick)  pcnt <= pcnt - PCNT_W'(1);
   end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wr_data,
   input  logic             inc,
   output logic [CNT_W-1:0] value,
   output logic             wrapped
);
   localparam logic [CNT_W-1:0] TOP = '1;

   generate
      if (CNT_W != 16) begin : g_bad
         $error("evt_count_core: count is built from two bytes, CNT_W must be 16");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value   <= '0;
         wrapped <= 1'b0;
      end else begin
         wrapped <= 1'b0;
         if (clr) begin
            value <= '0;
         end else if (wr_lo || wr_hi) begin
            if (wr_lo) value[7:0]  <= wr_data;
            if (wr_hi) value[15:8] <= wr_data;
         end else if (inc) begin
            value   <= value + CNT_W'(1);
            wrapped <= (value == TOP);
         end
      end
   end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import evt_timer16_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             wr_ctl,
   input  logic [7:0]       wr_data,
   input  logic             ext_clk,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] cmp_value,
   input  logic             cmp_clear,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       ctl_rd,
   output logic             ovf_irq,
   output logic             cmp_eq
);
   tmr_ctl_t            ctl_q;
   tmr_ctl_t            ctl_new;
   logic                ext_rise;
   logic                tick;
   logic                ps_load;
   logic [CTL_PS_W-1:0] ps_sel;
   logic                inc;
   logic                eq_now;
   logic                eq_prev;

   assign ctl_new = ctl_unpack(wr_data);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= ctl_new;

   assign ctl_rd = ctl_pack(ctl_q);

   evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk),
      .rise     (ext_rise)
   );

   assign tick    = ctl_q.en && (ctl_q.src ? ext_rise : 1'b1);
   assign ps_load = wr_ctl && (ctl_new.ps != ctl_q.ps);
   assign ps_sel  = ps_load ? ctl_new.ps : ctl_q.ps;

   evt_prescaler #(.SEL_W(CTL_PS_W)) u_ps (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (ps_load),
      .ratio_sel (ps_sel),
      .carry     (inc)
   );

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cmp_clear),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .inc     (inc),
      .value   (count),
      .wrapped (ovf_irq)
   );

   assign eq_now = cmp_en && (count == cmp_value);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) eq_prev <= 1'b0;
      else        eq_prev <= eq_now;

   assign cmp_eq = eq_now & ~eq_prev;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_lo,
   input logic             wr_hi,
   input logic             wr_ctl,
   input logic             cmp_en,
   input logic [CNT_W-1:0] cmp_value,
   input logic             cmp_clear,
   input logic [CNT_W-1:0] count,
   input logic [7:0]       ctl_rd,
   input logic             ovf_irq,
   input logic             cmp_eq
);
   a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_clear |=> (count == '0));

   a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (count == '0));

   a_r3_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |=> !ovf_irq);

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rd[0] && !wr_lo && !wr_hi && !cmp_clear) |=> $stable(count));

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi && !cmp_clear) |=>
         (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

   a_r2_ratio_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd[0] && !ctl_rd[1] && ctl_rd[5:4] == 2'd0 &&
       !wr_ctl && !wr_lo && !wr_hi && !cmp_clear) |=>
         (count == $past(count) + CNT_W'(1)));

   a_r9_eq_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_eq |-> (cmp_en && count == cmp_value));

   a_r9_eq_once: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_eq |=> !cmp_eq);

   a_r10_ctl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd[7:6] == 2'b00) && (ctl_rd[3:2] == 2'b00));
endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_lo     (wr_lo),
   .wr_hi     (wr_hi),
   .wr_ctl    (wr_ctl),
   .cmp_en    (cmp_en),
   .cmp_value (cmp_value),
   .cmp_clear (cmp_clear),
   .count     (count),
   .ctl_rd    (ctl_rd),
   .ovf_irq   (ovf_irq),
   .cmp_eq    (cmp_eq)
);

// File: tb/evt_timer16_tb.sv
module evt_timer16_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_lo = 0, wr_hi = 0, wr_ctl = 0;
   logic [7:0]  wr_data = 0;
   logic        ext_clk = 0, cmp_en = 0, cmp_clear = 0;
   logic [15:0] cmp_value = 0;
   logic [15:0] count;
   logic [7:0]  ctl_rd;
   logic        ovf_irq, cmp_eq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   evt_timer16 u_dut (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
      .wr_data(wr_data), .ext_clk(ext_clk), .cmp_en(cmp_en),
      .cmp_value(cmp_value), .cmp_clear(cmp_clear), .count(count),
      .ctl_rd(ctl_rd), .ovf_irq(ovf_irq), .cmp_eq(cmp_eq)
   );

   // reference model state, built from the requirements
   logic [15:0] m_cnt = 0;
   logic [3:0]  m_pc = 1;
   logic [7:0]  m_ctl = 0;
   logic        m_s0 = 0, m_s1 = 0, m_pv = 0, m_eqp = 0, m_ovf = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_update();
      logic edge_seen, tick, inc;
      edge_seen = m_s1 & ~m_pv;
      tick = m_ctl[0] && (m_ctl[1] ? edge_seen : 1'b1);
      inc = 0;
      if (wr_ctl && wr_data[5:4] != m_ctl[5:4]) m_pc = 4'd1 << wr_data[5:4];
      else if (tick) begin
         if (m_pc == 4'd1) begin m_pc = 4'd1 << m_ctl[5:4]; inc = 1; end
         else m_pc = m_pc - 4'd1;
      end
      m_eqp = cmp_en && (m_cnt == cmp_value);
      m_ovf = 0;
      if (cmp_clear) m_cnt = 0;
      else if (wr_lo || wr_hi) begin
         if (wr_lo) m_cnt[7:0] = wr_data;
         if (wr_hi) m_cnt[15:8] = wr_data;
      end else if (inc) begin
         m_ovf = (m_cnt == 16'hFFFF);
         m_cnt = m_cnt + 16'd1;
      end
      if (wr_ctl) m_ctl = wr_data & 8'h33;
      m_pv = m_s1; m_s1 = m_s0; m_s0 = ext_clk;
   endtask

   // one clock: model at the edge, compare 5 ns later, return at the falling edge
   task automatic step();
      @(posedge clk);
      model_update();
      #5;
      chk("R2/count", count, m_cnt);
      chk("R3/ovf_irq", ovf_irq, m_ovf);
      chk("R9/cmp_eq", cmp_eq, cmp_en && (m_cnt == cmp_value) && !m_eqp);
      chk("R10/ctl_rd", ctl_rd, m_ctl);
      @(negedge clk);
      wr_lo = 0; wr_hi = 0; wr_ctl = 0; cmp_clear = 0;
   endtask

   task automatic write_ctl(input logic [7:0] d);
      wr_ctl = 1; wr_data = d; step();
   endtask

   task automatic write_cnt(input logic [15:0] v);
      wr_lo = 1; wr_hi = 1; wr_data = v[7:0]; step();
      wr_hi = 1; wr_data = v[15:8]; step();
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 ctl_rd", ctl_rd, 0);
      chk("R1 ovf_irq", ovf_irq, 0);
      chk("R1 cmp_eq", cmp_eq, 0);
      rst_n = 1;
      step();

      // R10 read-back masks unused bits
      write_ctl(8'hCC);
      chk("R10 masked", ctl_rd, 8'h00);

      // R3 wrap from 0xFFFE with ratio 1, internal
      write_cnt(16'hFFFE);
      write_ctl(8'h01);
      step();
      chk("R3 pre-wrap", count, 16'hFFFF);
      step();
      chk("R3 wrap count", count, 16'h0000);
      chk("R3 wrap irq", ovf_irq, 1);
      step();
      chk("R3 irq one cycle", ovf_irq, 0);

      // R5 and R8: ratio 4, byte write mid-period keeps prescaler phase
      write_ctl(8'h00);
      write_cnt(16'h0000);
      write_ctl(8'h21);            // prescaler reloaded to 4
      step(); step();               // phase 4->3->2
      wr_lo = 1; wr_data = 8'h10; step();
      chk("R5 low write", count, 16'h0010);
      step();
      chk("R5 prescaler kept", count, 16'h0011);
      step(); step();
      write_ctl(8'h21);            // same field: no reload (R8)
      step();
      chk("R8 same-field no reload", count, 16'h0012);

      // R7 freeze and resume
      write_ctl(8'h20);
      step(); step(); step();
      chk("R7 frozen", count, 16'h0012);

      // R6 clear beats a write
      cmp_clear = 1; wr_hi = 1; wr_data = 8'hAA; step();
      chk("R6 clear", count, 16'h0000);

      // R4 external source, ratio 1: third edge after sampling
      write_ctl(8'h03);
      ext_clk = 1; step(); step();
      chk("R4 not yet", count, 16'h0000);
      step();
      chk("R4 counted", count, 16'h0001);
      ext_clk = 0; step(); step(); step();

      // R9 equality pulse held window
      cmp_value = 16'h0001; cmp_en = 1; step();
      chk("R9 held low", cmp_eq, 0);
      cmp_en = 0; step(); cmp_en = 1; #5;
      chk("R9 re-pulse", cmp_eq, 1);
      @(negedge clk); step();

      // constrained random phase, checked every cycle by the model
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         ext_clk = ($urandom_range(0, 2) == 0) ? ~ext_clk : ext_clk;
         if (r < 3) begin wr_ctl = 1; wr_data = 8'($urandom); end
         else if (r < 5) begin wr_lo = 1; wr_data = 8'($urandom); end
         else if (r < 7) begin wr_hi = 1; wr_data = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom); end
         else if (r < 8) cmp_clear = 1;
         if ($urandom_range(0, 9) == 0) cmp_en = ~cmp_en;
         if ($urandom_range(0, 19) == 0) cmp_value = m_cnt + 16'($urandom_range(0, 6));
         step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule